// File: doc/BRIEF.md
# Keyboard/Mouse Wake Event Controller

This block turns activity on a PS/2 keyboard and mouse into a power-management wake request. It also decides whether the PS/2 clock and data lines reach the legacy keyboard controller. It watches four sources:

- the keyboard controller's keyboard interrupt,
- its mouse interrupt,
- a falling edge on the keyboard data line,
- a falling edge on the mouse data line.

Each source sets its own sticky status bit. The wake output is raised when a status bit, that source's enable bit and a global enable are all true.

The two interrupt sources count only while main power is good. The data-line sources keep working on standby power alone, so a key press or mouse movement can wake a sleeping system.

Isolation bits hold the controller-side PS/2 lines at the idle-high level while the system sleeps. The data lines still feed the wake logic while isolated. A separate non-self-clearing bit holds the keyboard controller in reset.

Software reaches all state through a small synchronous register port. Reads are combinational.

Top module: `kbm_wake_ctrl`

## Requirements
- R1: A falling edge on `kbd_dat_i` sets status bit 2, and one on `ms_dat_i` sets status bit 3. Each input passes a two-flop synchronizer, so the bit reads 1 after the third rising clock edge following the change, and not before. Each edge produces one set only: a line held low does not set the bit again after it is cleared.
- R2: While `vcc_good_i` is 1, a high `kbd_irq_i` sampled at a clock edge sets status bit 0, and a high `ms_irq_i` sets status bit 1. While `vcc_good_i` is 0, the interrupt inputs have no effect.
- R3: The data-edge sources (status bits 2 and 3) set their bits while `vcc_good_i` is 0, just as they do while it is 1.
- R4: While `vcc_good_i` is 0, status bits 0 and 1 read as 0. The following are all retained: the enables at address 1, the global enable at address 2, the isolation bits at address 3, and status bits 2 and 3.
- R5: Status (address 0, bits 3:0) is sticky and clears only when 1 is written to a bit. Writing 0 leaves a bit unchanged. A set event in the same cycle as a clear of the same bit wins.
- R6: `wake_o` is 1 exactly when the global enable (address 2, bit 0) is 1 and, for some bit k, both status bit k and enable bit k (address 1, bits 3:0) are 1.
- R7: When isolation register (address 3) bit 6 is 1, `ms_clk_o` and `ms_dat_o` are driven to 1. When the bit is 0, they follow `ms_clk_i` and `ms_dat_i`.
- R8: When isolation register bit 5 is 1, `kbd_clk_o` and `kbd_dat_o` are driven to 1. When the bit is 0, they follow `kbd_clk_i` and `kbd_dat_i`.
- R9: The isolation bits do not affect the data lines that feed edge detection. A data edge under isolation still sets its status bit.
- R10: `kbc_rst_o` follows bit 6 of the configuration register at address 4. Writing 0x40 asserts it and writing 0x00 releases it. It holds its value until the next write to that address.
- R11: After reset the following are all 0: status, enables, global enable, isolation bits and `kbc_rst_o`. `wake_o` is 0, and the controller-side lines follow their inputs. Unused addresses and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Standby-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vcc_good_i | input | 1 | Main power good |
| kbd_irq_i | input | 1 | Keyboard interrupt from controller |
| ms_irq_i | input | 1 | Mouse interrupt from controller |
| kbd_clk_i | input | 1 | Keyboard clock from connector |
| kbd_dat_i | input | 1 | Keyboard data from connector |
| ms_clk_i | input | 1 | Mouse clock from connector |
| ms_dat_i | input | 1 | Mouse data from connector |
| kbd_clk_o | output | 1 | Keyboard clock toward controller |
| kbd_dat_o | output | 1 | Keyboard data toward controller |
| ms_clk_o | output | 1 | Mouse clock toward controller |
| ms_dat_o | output | 1 | Mouse data toward controller |
| kbc_rst_o | output | 1 | Keyboard controller reset |
| wake_o | output | 1 | Wake request |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |

## Verification
A source can set a status bit in the same cycle that software writes 1 to clear it. The bench provokes this by holding the keyboard interrupt high during a write-1 clear of bit 0. It passes only if the bit reads 1 afterwards.

A second pair of events meets in one cycle when main power drops just as a data edge arrives. The bench checks that the interrupt bits read 0 while the edge bit still sets.

Random write-1 clear masks against random enable patterns judge the wake output cycle by cycle against a model of the status.

// File: rtl/kbm_wake_pkg.sv
package kbm_wake_pkg;
  localparam int NUM_SRC  = 4;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 8;
  localparam int SRC_KIRQ = 0;
  localparam int SRC_MIRQ = 1;
  localparam int SRC_KDAT = 2;
  localparam int SRC_MDAT = 3;
  localparam int IRQ_MSB  = SRC_MIRQ;

  localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] A_ENABLE = 3'd1;
  localparam logic [ADDR_W-1:0] A_GLOBAL = 3'd2;
  localparam logic [ADDR_W-1:0] A_ISO    = 3'd3;
  localparam logic [ADDR_W-1:0] A_KBCCFG = 3'd4;

  localparam int ISO_MS_BIT  = 6;
  localparam int ISO_KBD_BIT = 5;
  localparam int KBC_RST_BIT = 6;
endpackage

// File: rtl/kbm_edge_det.sv
module kbm_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dat_i,
  output logic fall_o
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;

  // idle-high reset avoids a false edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[SH_W-2:0], dat_i};
  end

  assign fall_o = sh_q[SH_W-1] & ~sh_q[SH_W-2];

  AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R1
endmodule

// File: rtl/kbm_iso_gate.sv
module kbm_iso_gate #(
  parameter int LANES = 2
) (
  input  logic             block_i,
  input  logic [LANES-1:0] line_i,
  output logic [LANES-1:0] line_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign line_o[g] = block_i ? 1'b1 : line_i[g];
  end
endmodule

// File: rtl/kbm_wake_status.sv
module kbm_wake_status
  import kbm_wake_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vcc_good_i,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               gen_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic               wake_o
);
  logic [NUM_SRC-1:0] st_q, st_d, set_eff;

  always_comb begin
    set_eff = set_i;
    if (!vcc_good_i) set_eff[IRQ_MSB:0] = '0;
    st_d = (st_q & ~clr_i) | set_eff;
    if (!vcc_good_i) st_d[IRQ_MSB:0] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign status_o = st_q;
  assign wake_o   = gen_i & |(st_q & en_i);

  AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcc_good_i |=> (st_q[IRQ_MSB:0] == '0)); // R4
  AST_WAKE_GLOBAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> gen_i); // R6

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_chk
    if (k <= IRQ_MSB) begin : g_irq
      AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[k] && vcc_good_i |=> st_q[k]); // R2
      AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q[k] && !clr_i[k] && vcc_good_i |=> st_q[k]); // R5
    end else begin : g_edge
      AST_EDGE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[k] |=> st_q[k]); // R3
      AST_EDGE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q[k] && !clr_i[k] |=> st_q[k]); // R5
    end
  end
endmodule

// File: rtl/kbm_wake_regs.sv
module kbm_wake_regs
  import kbm_wake_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] status_i,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic               gen_o,
  output logic               kbd_iso_o,
  output logic               ms_iso_o,
  output logic               kbc_rst_o
);
  logic [NUM_SRC-1:0] en_q;
  logic gen_q, kiso_q, miso_q, krst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      gen_q  <= 1'b0;
      kiso_q <= 1'b0;
      miso_q <= 1'b0;
      krst_q <= 1'b0;
    end else if (we_i) begin
      unique case (addr_i)
        A_ENABLE: en_q  <= wdata_i[NUM_SRC-1:0];
        A_GLOBAL: gen_q <= wdata_i[0];
        A_ISO: begin
          kiso_q <= wdata_i[ISO_KBD_BIT];
          miso_q <= wdata_i[ISO_MS_BIT];
        end
        A_KBCCFG: krst_q <= wdata_i[KBC_RST_BIT];
        default: ;
      endcase
    end
  end

  assign clr_o = (we_i && addr_i == A_STATUS) ? wdata_i[NUM_SRC-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_STATUS: rdata_o[NUM_SRC-1:0] = status_i;
      A_ENABLE: rdata_o[NUM_SRC-1:0] = en_q;
      A_GLOBAL: rdata_o[0]           = gen_q;
      A_ISO: begin
        rdata_o[ISO_KBD_BIT] = kiso_q;
        rdata_o[ISO_MS_BIT]  = miso_q;
      end
      A_KBCCFG: rdata_o[KBC_RST_BIT] = krst_q;
      default: ;
    endcase
  end

  assign en_o      = en_q;
  assign gen_o     = gen_q;
  assign kbd_iso_o = kiso_q;
  assign ms_iso_o  = miso_q;
  assign kbc_rst_o = krst_q;

  AST_KBC_RST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == A_KBCCFG) |=> $stable(kbc_rst_o)); // R10
endmodule

// File: rtl/kbm_wake_ctrl.sv
module kbm_wake_ctrl
  import kbm_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vcc_good_i,
  input  logic              kbd_irq_i,
  input  logic              ms_irq_i,
  input  logic              kbd_clk_i,
  input  logic              kbd_dat_i,
  input  logic              ms_clk_i,
  input  logic              ms_dat_i,
  output logic              kbd_clk_o,
  output logic              kbd_dat_o,
  output logic              ms_clk_o,
  output logic              ms_dat_o,
  output logic              kbc_rst_o,
  output logic              wake_o,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  logic [NUM_SRC-1:0] set_w, clr_w, en_w, status_w;
  logic gen_w, kiso_w, miso_w, kfall_w, mfall_w;

  // wake path taps connector-side data, ahead of the isolation gates
  kbm_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_kdat_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .dat_i(kbd_dat_i), .fall_o(kfall_w));
  kbm_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_mdat_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .dat_i(ms_dat_i), .fall_o(mfall_w));

  always_comb begin
    set_w           = '0;
    set_w[SRC_KIRQ] = kbd_irq_i;
    set_w[SRC_MIRQ] = ms_irq_i;
    set_w[SRC_KDAT] = kfall_w;
    set_w[SRC_MDAT] = mfall_w;
  end

  kbm_wake_status u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .vcc_good_i(vcc_good_i),
    .set_i(set_w), .clr_i(clr_w), .en_i(en_w), .gen_i(gen_w),
    .status_o(status_w), .wake_o(wake_o));

  kbm_wake_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .status_i(status_w),
    .clr_o(clr_w), .en_o(en_w), .gen_o(gen_w), .kbd_iso_o(kiso_w),
    .ms_iso_o(miso_w), .kbc_rst_o(kbc_rst_o));

  kbm_iso_gate #(.LANES(2)) u_kbd_gate (
    .block_i(kiso_w), .line_i({kbd_clk_i, kbd_dat_i}),
    .line_o({kbd_clk_o, kbd_dat_o}));
  kbm_iso_gate #(.LANES(2)) u_ms_gate (
    .block_i(miso_w), .line_i({ms_clk_i, ms_dat_i}),
    .line_o({ms_clk_o, ms_dat_o}));

  AST_MS_ISO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miso_w |-> ms_clk_o && ms_dat_o); // R7
  AST_KBD_ISO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kiso_w |-> kbd_clk_o && kbd_dat_o); // R8
  AST_EDGE_UNDER_ISO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kfall_w |=> status_w[SRC_KDAT]); // R9
endmodule

// File: tb/kbm_wake_ctrl_tb_top.sv
module kbm_wake_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, vcc = 1'b1;
  logic kirq = 0, mirq = 0, kclk = 1, kdat = 1, mclk = 1, mdat = 1;
  logic kclk_o, kdat_o, mclk_o, mdat_o, krst, wake;
  logic we = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  kbm_wake_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .vcc_good_i(vcc), .kbd_irq_i(kirq),
    .ms_irq_i(mirq), .kbd_clk_i(kclk), .kbd_dat_i(kdat), .ms_clk_i(mclk),
    .ms_dat_i(mdat), .kbd_clk_o(kclk_o), .kbd_dat_o(kdat_o),
    .ms_clk_o(mclk_o), .ms_dat_o(mdat_o), .kbc_rst_o(krst), .wake_o(wake),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata));

  function automatic logic exp_wake(logic [3:0] st, logic [3:0] en, logic g);
    return g & |(st & en);
  endfunction

  function automatic logic [3:0] exp_gate(logic iso, logic [1:0] pins);
    return iso ? 2'b11 : pins;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // drive a data line low, hold, then restore high
  task automatic kedge();
    @(negedge clk); kdat = 0; idle(4); kdat = 1; idle(4);
  endtask

  task automatic medge();
    @(negedge clk); mdat = 0; idle(4); mdat = 1; idle(4);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [3:0] st, en, msk;
    logic g;
    void'($urandom(32'd7151));
    idle(3);
    // R11 reset state
    for (int a = 0; a < 8; a++) begin rd(3'(a), d); check("R11 reset read", d, 8'h00); end
    #1 check("R11 wake/krst", {6'b0, wake, krst}, 8'h00);
    kclk = 0; #1 check("R11 pass-through", {4'b0, kclk_o, kdat_o, mclk_o, mdat_o}, 8'b0111);
    kclk = 1;
    rst_n = 1;
    idle(2);

    // R2 interrupts under main power
    @(negedge clk); kirq = 1; @(negedge clk); kirq = 0;
    rd(0, d); check("R2 kbd irq sets bit0", d, 8'h01);
    @(negedge clk); mirq = 1; @(negedge clk); mirq = 0;
    rd(0, d); check("R2 mouse irq sets bit1", d, 8'h03);

    // R1 latency: change before E1, status visible after E3
    wr(0, 8'h0f);
    kdat = 0;
    idle(2); rd(0, d); check("R1 not before third edge", d, 8'h00);
    idle(1); rd(0, d); check("R1 set after third edge", d, 8'h04);
    wr(0, 8'h04); idle(5);
    rd(0, d); check("R1 one set per edge", d, 8'h00);
    kdat = 1; idle(4);
    medge(); rd(0, d); check("R1 mouse edge bit3", d, 8'h08);
    wr(0, 8'h0f);

    // R4/R3 standby only: configure, drop power, check retention
    wr(1, 8'h0c); wr(2, 8'h01); wr(3, 8'h00);
    @(negedge clk); kirq = 1;
    vcc = 0; mdat = 0;                 // power drop meets a data edge
    idle(5); kirq = 0; mdat = 1; idle(4);
    rd(0, d); check("R3 edge sets with main power off", d, 8'h08);
    check("R2 irq ignored without main power", {7'b0, d[0]}, 8'h00);
    #1 check("R6 wake on standby", {7'b0, wake}, 8'h01);
    rd(1, d); check("R4 enables retained", d, 8'h0c);
    rd(2, d); check("R4 global retained", d, 8'h01);
    vcc = 1; idle(2);
    rd(0, d); check("R4 edge status retained", d, 8'h08);

    // R4 irq status dropped when power goes away
    @(negedge clk); kirq = 1; @(negedge clk); kirq = 0;
    rd(0, d); check("R4 irq bit set before drop", d, 8'h09);
    vcc = 0; idle(1);
    rd(0, d); check("R4 irq bit cleared off power", d, 8'h08);
    vcc = 1; wr(0, 8'h0f);

    // R5 sticky, write-0 no effect, collision
    @(negedge clk); kirq = 1; @(negedge clk); kirq = 0;
    wr(0, 8'h00); rd(0, d); check("R5 write 0 keeps bit", d, 8'h01);
    kirq = 1; wr(0, 8'h01); kirq = 0;
    rd(0, d); check("R5 set wins over clear", d, 8'h01);
    wr(0, 8'h01); rd(0, d); check("R5 w1c clears", d, 8'h00);

    // R6 random wake against model
    for (int i = 0; i < 40; i++) begin
      wr(0, 8'h0f);
      @(negedge clk); kirq = 1; mirq = 1; @(negedge clk); kirq = 0; mirq = 0;
      kedge(); medge();
      msk = 4'($urandom); en = 4'($urandom); g = 1'($urandom);
      wr(0, {4'b0, msk}); wr(1, {4'b0, en}); wr(2, {7'b0, g});
      st = 4'hf & ~msk;
      rd(0, d); check("R5 random w1c", d, {4'b0, st});
      #1 check("R6 wake model", {7'b0, wake}, {7'b0, exp_wake(st, en, g)});
    end
    wr(1, 8'h00); wr(2, 8'h00); wr(0, 8'h0f);

    // R7/R8 random gating
    for (int i = 0; i < 60; i++) begin
      d = 8'($urandom) & 8'h60;
      wr(3, d);
      {kclk, kdat, mclk, mdat} = 4'($urandom);
      #1;
      check("R8 kbd gate", {6'b0, kclk_o, kdat_o}, {6'b0, 2'(exp_gate(d[5], {kclk, kdat}))});
      check("R7 mouse gate", {6'b0, mclk_o, mdat_o}, {6'b0, 2'(exp_gate(d[6], {mclk, mdat}))});
    end
    {kclk, kdat, mclk, mdat} = 4'hf; idle(4); wr(0, 8'h0f);

    // R9 isolation leaves wake data path intact
    wr(3, 8'h60);
    kedge(); medge();
    rd(0, d); check("R9 edges under isolation", d, 8'h0c);
    #1 check("R9 controller side idle", {4'b0, kclk_o, kdat_o, mclk_o, mdat_o}, 8'h0f);
    rd(3, d); check("R7 iso readback", d, 8'h60);
    wr(3, 8'h00); wr(0, 8'h0f);

    // R10 controller reset
    wr(4, 8'h40); idle(20);
    #1 check("R10 reset asserted and held", {7'b0, krst}, 8'h01);
    rd(4, d); check("R10 readback", d, 8'h40);
    wr(4, 8'h00);
    #1 check("R10 reset released", {7'b0, krst}, 8'h00);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule